// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter with Bus Handshake

This block sits between four peripheral request lines and a CPU that owns the system bus. When an enabled channel asks for service, the block requests the bus from the CPU. It waits until the CPU grants it, picks one channel, and pulls that channel's active-low acknowledge low for one transfer cycle. During that cycle it presents the channel's current memory address. The low byte goes out directly. The upper byte goes out together with a strobe, so external logic can latch it. The channel's address then steps up by one and its remaining count steps down by one.

Channels are chosen by either a fixed order or a rotating order, set through a small register port. The CPU uses the same port to load each channel's 16-bit start address and 14-bit transfer count. When a channel issues its final transfer, the block flags it, records it in a status register and disables the channel. A separate pulse marks every 128th transfer since the channel's count was loaded. While the block owns the bus, the register port does not act on writes.

Top module: `dmx_engine`

## Requirements
- R1: After a synchronous reset, `hrq` is 0, `dack_n` is 4'hF, and `adstb`, `tc`, `mark` and `bus_own` are 0. The mode and status registers read 0.
- R2: One cycle after an enabled channel's `drq` is high, `hrq` goes to 1. No `dack_n` bit goes low while `hlda` stays 0.
- R3: Suppose `hrq` is 1 and `hlda` is sampled 1 with an enabled request pending. On the next cycle exactly one `dack_n` bit (bit i for channel i) is 0, and it stays low for exactly one cycle.
- R4: When mode bit 4 is 0 (fixed order), channel 0 wins over 1, 1 over 2, and 2 over 3.
- R5: When mode bit 4 is 1 (rotating order), the channel served last becomes the lowest priority and the next channel number becomes the highest. Every mode write restarts the order with channel 0 highest.
- R6: A channel whose enable bit (mode bits 3:0, bit i for channel i) is 0 is ignored. Its request neither raises `hrq` nor wins arbitration.
- R7: During the acknowledge cycle, `bus_addr` carries bits 7:0 and `hi_byte` carries bits 15:8 of the channel's address. After the transfer, the address reads back one higher and the count one lower.
- R8: A transfer made with a count of 1 or 0 pulses `tc` during its acknowledge cycle. It also sets that channel's bit in the status register (bits 3:0) and clears the channel's enable bit.
- R9: A write to the mode register clears all status bits.
- R10: `adstb` pulses during the acknowledge cycle of the first transfer after `hrq` rises. It also pulses on any transfer whose address bits 15:8 differ from those of the previous transfer.
- R11: `mark` pulses during the acknowledge cycle of every 128th transfer of a channel, counted from the last write of that channel's count.
- R12: Once the acknowledge has gone high, `hrq` drops one cycle later if no enabled request is pending. Otherwise the block keeps `hrq` high and arbitrates again.
- R13: Register writes during the acknowledge cycle and during the cycle after it (`bus_own` = 1) have no effect.
- R14: Register select map: value 2i selects channel i's address and 2i+1 selects its count. Value 8 selects mode (bits 3:0 enables, bit 4 rotating) and value 9 selects status. `reg_rdata` returns the selected register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register contents |
| drq | input | 4 | Per-channel service requests |
| hlda | input | 1 | Bus grant from the CPU |
| hrq | output | 1 | Bus request to the CPU |
| dack_n | output | 4 | Active-low per-channel acknowledge |
| bus_addr | output | 8 | Low address byte during a transfer |
| hi_byte | output | 8 | Upper address byte during a transfer |
| adstb | output | 1 | Upper-address latch strobe |
| tc | output | 1 | Final-transfer pulse |
| mark | output | 1 | Every-128th-transfer pulse |
| bus_own | output | 1 | High while the block drives the bus |

## Verification
The assertions check several properties on every cycle:
- At most one acknowledge is low at a time, and it never lasts more than one cycle.
- An acknowledge only follows a cycle in which the bus was both requested and granted.
- `tc`, `adstb` and `mark` appear only inside an acknowledge.
- The bus request only falls after a cycle with no acknowledge.

Only the bench's scenarios can show the rest:
- which channel wins under fixed and rotating order, and that rotation restarts on a mode write;
- the address and count arithmetic;
- the final-transfer status and auto-disable;
- the exact pattern of upper-address strobes across a page crossing;
- the 128-transfer mark spacing;
- that writes are dropped while the bus is owned.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    localparam int CH_N       = 4;
    localparam int CH_W       = $clog2(CH_N);
    localparam int SEL_W      = CH_W + 2;
    localparam int DW_D       = 16;
    localparam int AW_D       = 16;
    localparam int CW_D       = 14;
    localparam int MARK_LEN_D = 128;
    localparam int BYTE_W     = 8;

    localparam logic [SEL_W-1:0] SEL_MODE = SEL_W'(2 * CH_N);
    localparam logic [SEL_W-1:0] SEL_STAT = SEL_W'(2 * CH_N + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER,
        ST_POST
    } dmx_state_e;

    typedef struct packed {
        logic [CH_N-1:0] en;
        logic            rot;
    } dmx_mode_t;

    function automatic logic [CH_N-1:0] ch_onehot(input logic [CH_W-1:0] ch);
        logic [CH_N-1:0] r;
        r     = '0;
        r[ch] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/dmx_chan.sv
module dmx_chan #(
    parameter int DW       = 16,
    parameter int AW       = 16,
    parameter int CW       = 14,
    parameter int MARK_LEN = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic [DW-1:0] wdata,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] cnt,
    output logic          last,
    output logic          mark_hit
);
    localparam int MW = $clog2(MARK_LEN);

    logic [MW-1:0] mcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            cnt  <= '0;
            mcnt <= '0;
        end else begin
            if (wr_addr) addr <= wdata[AW-1:0];
            if (wr_cnt) begin
                cnt  <= wdata[CW-1:0];
                mcnt <= '0;
            end
            if (step) begin
                addr <= addr + 1'b1;
                cnt  <= cnt - 1'b1;
                mcnt <= (mcnt == MW'(MARK_LEN - 1)) ? '0 : mcnt + 1'b1;
            end
        end
    end

    // Final transfer when one or none remain.
    assign last     = (cnt <= CW'(1));
    assign mark_hit = (mcnt == MW'(MARK_LEN - 1));
endmodule

// File: rtl/dmx_prio.sv
module dmx_prio #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] req,
    input  logic         rot,
    input  logic [W-1:0] last_ch,
    output logic [W-1:0] win,
    output logic         hit
);
    int base;

    always_comb begin
        base = 0;
        if (rot) base = (int'(last_ch) == N - 1) ? 0 : int'(last_ch) + 1;
        win = '0;
        hit = 1'b0;
        // Walk from lowest priority to highest so the highest request wins.
        for (int i = N - 1; i >= 0; i--) begin
            if (req[(base + i) % N]) begin
                win = W'((base + i) % N);
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dmx_engine.sv
module dmx_engine
    import dmx_pkg::*;
#(
    parameter int DW       = DW_D,
    parameter int AW       = AW_D,
    parameter int CW       = CW_D,
    parameter int MARK_LEN = MARK_LEN_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [CH_N-1:0]   drq,
    input  logic              hlda,
    output logic              hrq,
    output logic [CH_N-1:0]   dack_n,
    output logic [BYTE_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] hi_byte,
    output logic              adstb,
    output logic              tc,
    output logic              mark,
    output logic              bus_own
);
    dmx_state_e        st;
    dmx_mode_t         mode;
    logic [CH_W-1:0]   cur;
    logic [CH_W-1:0]   last_srv;
    logic [CH_N-1:0]   tcf;
    logic              first_x;
    logic [BYTE_W-1:0] hi_prev;

    logic [AW-1:0]     ch_addr [CH_N];
    logic [CW-1:0]     ch_cnt  [CH_N];
    logic [CH_N-1:0]   ch_last;
    logic [CH_N-1:0]   ch_mark;

    logic [CH_N-1:0]   req_v;
    logic              pending;
    logic [CH_W-1:0]   win;
    logic              win_hit;
    logic              owned;
    logic              wr_ok;
    logic              is_chan;
    logic [CH_W-1:0]   sel_ch;
    logic              mode_wr;
    logic              in_xfer;
    logic [AW-1:0]     cur_addr;
    logic [BYTE_W-1:0] cur_hi;

    assign req_v    = drq & mode.en;
    assign pending  = |req_v;
    assign owned    = (st == ST_XFER) || (st == ST_POST);
    assign in_xfer  = (st == ST_XFER);
    assign wr_ok    = reg_wr && !owned;
    assign is_chan  = !reg_sel[SEL_W-1];
    assign sel_ch   = reg_sel[SEL_W-2:1];
    assign mode_wr  = wr_ok && (reg_sel == SEL_MODE);
    assign cur_addr = ch_addr[cur];
    assign cur_hi   = cur_addr[AW-1:AW-BYTE_W];

    dmx_prio #(.N(CH_N), .W(CH_W)) u_prio (
        .req     (req_v),
        .rot     (mode.rot),
        .last_ch (last_srv),
        .win     (win),
        .hit     (win_hit)
    );

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        dmx_chan #(.DW(DW), .AW(AW), .CW(CW), .MARK_LEN(MARK_LEN)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .wr_addr  (wr_ok && is_chan && (sel_ch == CH_W'(g)) && !reg_sel[0]),
            .wr_cnt   (wr_ok && is_chan && (sel_ch == CH_W'(g)) && reg_sel[0]),
            .wdata    (reg_wdata),
            .step     (in_xfer && (cur == CH_W'(g))),
            .addr     (ch_addr[g]),
            .cnt      (ch_cnt[g]),
            .last     (ch_last[g]),
            .mark_hit (ch_mark[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            mode     <= '0;
            cur      <= '0;
            last_srv <= CH_W'(CH_N - 1);
            tcf      <= '0;
            first_x  <= 1'b0;
            hi_prev  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (pending) begin
                        st      <= ST_WAIT;
                        first_x <= 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (!pending) begin
                        st <= ST_IDLE;
                    end else if (hlda && win_hit) begin
                        st  <= ST_XFER;
                        cur <= win;
                    end
                end
                ST_XFER: begin
                    st       <= ST_POST;
                    last_srv <= cur;
                    first_x  <= 1'b0;
                    hi_prev  <= cur_hi;
                    if (ch_last[cur]) begin
                        tcf[cur]     <= 1'b1;
                        mode.en[cur] <= 1'b0;
                    end
                end
                ST_POST: begin
                    st <= pending ? ST_WAIT : ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
            // Writes only land outside bus ownership, so never in ST_XFER.
            if (mode_wr) begin
                mode.en  <= reg_wdata[CH_N-1:0];
                mode.rot <= reg_wdata[CH_N];
                tcf      <= '0;
                last_srv <= CH_W'(CH_N - 1);
            end
        end
    end

    assign hrq      = (st != ST_IDLE);
    assign bus_own  = owned;
    assign dack_n   = in_xfer ? ~ch_onehot(cur) : '1;
    assign bus_addr = in_xfer ? cur_addr[BYTE_W-1:0] : '0;
    assign hi_byte  = in_xfer ? cur_hi : '0;
    assign adstb    = in_xfer && (first_x || (cur_hi != hi_prev));
    assign tc       = in_xfer && ch_last[cur];
    assign mark     = in_xfer && ch_mark[cur];

    always_comb begin
        reg_rdata = '0;
        if (is_chan) begin
            reg_rdata = reg_sel[0] ? DW'(ch_cnt[sel_ch]) : DW'(ch_addr[sel_ch]);
        end else if (reg_sel == SEL_MODE) begin
            reg_rdata = DW'({mode.rot, mode.en});
        end else if (reg_sel == SEL_STAT) begin
            reg_rdata = DW'(tcf);
        end
    end
endmodule

// File: rtl/dmx_engine_chk.sv
module dmx_engine_chk
    import dmx_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            hlda,
    input logic            hrq,
    input logic [CH_N-1:0] dack_n,
    input logic            adstb,
    input logic            tc,
    input logic            mark,
    input logic            bus_own
);
    a_r3_single_ack: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dack_n));

    a_r3_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (dack_n != '1) |=> (dack_n == '1));

    a_r2_ack_after_grant: assert property (@(posedge clk) disable iff (rst)
        (dack_n != '1) |-> ($past(hlda) && $past(hrq)));

    a_r12_release_after_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(hrq) |-> ($past(dack_n) == '1));

    a_r8_tc_in_ack: assert property (@(posedge clk) disable iff (rst)
        tc |-> (dack_n != '1));

    a_r10_strobe_in_ack: assert property (@(posedge clk) disable iff (rst)
        adstb |-> (dack_n != '1));

    a_r11_mark_in_ack: assert property (@(posedge clk) disable iff (rst)
        mark |-> (dack_n != '1));

    a_r13_own_needs_hold: assert property (@(posedge clk) disable iff (rst)
        bus_own |-> hrq);
endmodule

bind dmx_engine dmx_engine_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .hlda    (hlda),
    .hrq     (hrq),
    .dack_n  (dack_n),
    .adstb   (adstb),
    .tc      (tc),
    .mark    (mark),
    .bus_own (bus_own)
);

// File: tb/sim_dmx_engine.sv
module sim_dmx_engine;
    import dmx_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [SEL_W-1:0]  reg_sel = '0;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;
    logic [CH_N-1:0]   drq = '0;
    logic              hlda = 1'b0;
    logic              hrq;
    logic [CH_N-1:0]   dack_n;
    logic [7:0]        bus_addr;
    logic [7:0]        hi_byte;
    logic              adstb;
    logic              tc;
    logic              mark;
    logic              bus_own;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dmx_engine u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drq(drq),
        .hlda(hlda), .hrq(hrq), .dack_n(dack_n), .bus_addr(bus_addr),
        .hi_byte(hi_byte), .adstb(adstb), .tc(tc), .mark(mark),
        .bus_own(bus_own)
    );

    // {rotating, drq, expected dack_n}
    localparam logic [8:0] VEC [0:8] = '{
        {1'b0, 4'hF, 4'hE}, {1'b0, 4'hC, 4'hB}, {1'b0, 4'hA, 4'hD},
        {1'b0, 4'h8, 4'h7}, {1'b1, 4'hF, 4'hE}, {1'b1, 4'hF, 4'hD},
        {1'b1, 4'h9, 4'h7}, {1'b1, 4'hF, 4'hE}, {1'b1, 4'h3, 4'hD}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [SEL_W-1:0] sel, input logic [15:0] data);
        reg_sel   = sel;
        reg_wdata = data;
        reg_wr    = 1'b1;
        tick(1);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [SEL_W-1:0] sel, output logic [15:0] data);
        reg_sel = sel;
        #1;
        data = reg_rdata;
    endtask

    task automatic xfer(input bit keep, output logic [3:0] dk, output logic as,
                        output logic tcv, output logic mk, output logic [7:0] hb,
                        output logic [7:0] ba);
        dk = '1; as = 0; tcv = 0; mk = 0; hb = '0; ba = '0;
        for (int i = 0; i < 40; i++) begin
            tick(1);
            if (dack_n != '1) begin
                dk = dack_n; as = adstb; tcv = tc; mk = mark;
                hb = hi_byte; ba = bus_addr;
                if (!keep) drq = '0;
                return;
            end
        end
        chk("R3 no acknowledge", 32'(dack_n), 32'hE);
    endtask

    task automatic check_reset_state();
        logic [15:0] d;
        chk("R1 hrq", 32'(hrq), 0);
        chk("R1 dack_n", 32'(dack_n), 32'hF);
        chk("R1 strobes", 32'({adstb, tc, mark, bus_own}), 0);
        rd(SEL_MODE, d); chk("R1 mode", 32'(d), 0);
        rd(SEL_STAT, d); chk("R1 status", 32'(d), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [3:0]  dk;
        logic        as, tcv, mk;
        logic [7:0]  hb, ba;
        logic [15:0] d;
        logic        cur_rot;
        int          marks, mark_at;

        tick(3);
        rst = 1'b0;
        tick(1);
        check_reset_state();

        for (int g = 0; g < CH_N; g++) begin
            wr(SEL_W'(2 * g), 16'(16'h1000 * (g + 1)));
            wr(SEL_W'(2 * g + 1), 16'd100);
        end
        rd(SEL_W'(2), d); chk("R14 ch1 address map", 32'(d), 32'h2000);

        // Priority table walk (R4 fixed, R5 rotating)
        hlda = 1'b1;
        cur_rot = 1'b0;
        wr(SEL_MODE, 16'h000F);
        for (int v = 0; v < 9; v++) begin
            if (VEC[v][8] != cur_rot) begin
                cur_rot = VEC[v][8];
                wr(SEL_MODE, {11'd0, cur_rot, 4'hF});
            end
            drq = VEC[v][7:4];
            xfer(0, dk, as, tcv, mk, hb, ba);
            chk(cur_rot ? "R5 rotating winner" : "R4 fixed winner", 32'(dk), 32'(VEC[v][3:0]));
            tick(2);
        end

        // R2 / R12: request waits for grant, release timing
        wr(SEL_MODE, 16'h000F);
        hlda = 1'b0;
        drq  = 4'b0010;
        tick(1);
        chk("R2 hrq raised", 32'(hrq), 1);
        tick(3);
        chk("R2 no ack without hlda", 32'(dack_n), 32'hF);
        hlda = 1'b1;
        tick(1);
        chk("R3 ack after grant", 32'(dack_n), 32'hD);
        drq = '0;
        tick(1);
        chk("R3 ack one cycle", 32'(dack_n), 32'hF);
        chk("R12 hrq held in post cycle", 32'(hrq), 1);
        tick(1);
        chk("R12 hrq released", 32'(hrq), 0);

        // R7 address and count update
        wr(SEL_W'(2), 16'h2040);
        wr(SEL_W'(3), 16'd5);
        drq = 4'b0010;
        xfer(0, dk, as, tcv, mk, hb, ba);
        chk("R7 low address byte", 32'(ba), 32'h40);
        chk("R7 high address byte", 32'(hb), 32'h20);
        tick(2);
        rd(SEL_W'(2), d); chk("R7 address incremented", 32'(d), 32'h2041);
        rd(SEL_W'(3), d); chk("R7 count decremented", 32'(d), 4);

        // R6 disabled channel ignored
        wr(SEL_MODE, 16'h000B);
        drq = 4'b0100;
        tick(3);
        chk("R6 disabled request no hrq", 32'(hrq), 0);
        drq = 4'b1100;
        xfer(0, dk, as, tcv, mk, hb, ba);
        chk("R6 disabled channel skipped", 32'(dk), 32'h7);
        tick(2);

        // R8 / R9 terminal count
        wr(SEL_W'(3), 16'd2);
        wr(SEL_MODE, 16'h0002);
        drq = 4'b0010;
        xfer(0, dk, as, tcv, mk, hb, ba);
        chk("R8 no tc before last", 32'(tcv), 0);
        tick(2);
        drq = 4'b0010;
        xfer(0, dk, as, tcv, mk, hb, ba);
        chk("R8 tc on last", 32'(tcv), 1);
        tick(2);
        rd(SEL_STAT, d); chk("R8 status bit", 32'(d), 32'h2);
        rd(SEL_MODE, d); chk("R8 enable cleared", 32'(d), 0);
        drq = 4'b0010;
        tick(3);
        chk("R8 finished channel no hrq", 32'(hrq), 0);
        drq = '0;
        wr(SEL_MODE, 16'h0000);
        rd(SEL_STAT, d); chk("R9 status cleared", 32'(d), 0);

        // R10 upper-address strobe
        wr(SEL_W'(4), 16'h12FE);
        wr(SEL_W'(5), 16'd50);
        wr(SEL_MODE, 16'h0004);
        drq = 4'b0100;
        xfer(1, dk, as, tcv, mk, hb, ba);
        chk("R10 strobe on first", 32'({as, hb}), 32'h112);
        chk("R12 hrq kept while pending", 32'(hrq), 1);
        xfer(1, dk, as, tcv, mk, hb, ba);
        chk("R10 no strobe same page", 32'({as, ba}), 32'h0FF);
        xfer(0, dk, as, tcv, mk, hb, ba);
        chk("R10 strobe on page cross", 32'({as, hb}), 32'h113);
        tick(2);
        drq = 4'b0100;
        xfer(0, dk, as, tcv, mk, hb, ba);
        chk("R10 strobe after new hold", 32'({as, hb}), 32'h113);
        tick(2);

        // R11 mark spacing
        wr(SEL_W'(7), 16'd300);
        wr(SEL_MODE, 16'h0008);
        drq = 4'b1000;
        marks = 0;
        mark_at = 0;
        for (int i = 1; i <= 130; i++) begin
            xfer(i != 130, dk, as, tcv, mk, hb, ba);
            if (mk) begin
                marks++;
                mark_at = i;
            end
        end
        tick(2);
        chk("R11 one mark in 130", 32'(marks), 1);
        chk("R11 mark on 128th", 32'(mark_at), 128);

        // R13 writes ignored while owning the bus
        wr(SEL_W'(0), 16'h0500);
        wr(SEL_W'(1), 16'd10);
        wr(SEL_MODE, 16'h0001);
        drq = 4'b0001;
        xfer(0, dk, as, tcv, mk, hb, ba);
        reg_sel   = SEL_W'(0);
        reg_wdata = 16'hBEEF;
        reg_wr    = 1'b1;
        tick(1);
        chk("R13 bus_own in post cycle", 32'(bus_own), 1);
        reg_wr = 1'b0;
        tick(1);
        rd(SEL_W'(0), d); chk("R13 write ignored", 32'(d), 32'h0501);
        wr(SEL_W'(0), 16'hBEEF);
        rd(SEL_W'(0), d); chk("R14 write accepted when idle", 32'(d), 32'hBEEF);
        rd(SEL_MODE, d); chk("R14 mode map", 32'(d), 32'h1);

        // R1 reset in mid-run
        wr(SEL_MODE, 16'h001F);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
        check_reset_state();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule